// File: doc/BRIEF.md
# Paged CSR Window Decoder

This block sits between a 32-bit register-bus slave port and a register file that is larger than the bus can address directly. The bus sees a 12-bit byte offset space. One sub-range of that space, the top quarter where offset bits [11:10] are both 1, is a movable window. An access in the window is redirected to a 16-bit internal address. The high six bits of that address come from a page number stored in a control register, and the low ten bits come from the bus offset. Every other offset reaches the register file unchanged.

The control register sits at offset 0x808. It holds the page number and two independent enable bits, one for outbound transfers and one for inbound transfers. Software moves the window with a read-modify-write of this register. The new page applies to the very next bus access, with no wait cycle. A register-file model of 4096 words, indexed by internal byte address bits [13:2], is included so the remapping can be checked end to end. Pages 0 to 15 therefore map to distinct storage in the default build.

Top module: `csr_page_decoder`

## Requirements
- R1: After reset the page number is 0 and both enable outputs are 0. The read data output is 0, and a read of the control register returns 0.
- R2: A write to offset 0x808 loads the page number from write data bits [18:13], the outbound enable from bit 0 and the inbound enable from bit 1. A read of 0x808 returns those fields in the same positions, with every other bit 0.
- R3: When offset bits [11:10] are both 1, the internal address `rf_addr_o` is {page[5:0], offset[9:0]}. Reads and writes at that offset act on that register-file location.
- R4: When offset bits [11:10] are not both 1, `rf_addr_o` equals the offset zero-extended to 16 bits. This includes the offsets 0x400 and 0x804, each of which has only one of the two bits set.
- R5: An access at offset 0x808 reaches only the control register. A write there leaves the register-file word at internal address 0x0808 unchanged. That word stays reachable through page 2 at offset 0xC08.
- R6: An access on the cycle right after a control-register write uses the new page.
- R7: Read data appears on `rsp_rdata_o` one cycle after the read is presented. It holds its value through cycles that carry no read.
- R8: Register-file storage for the same window offset under different pages is distinct. Data written through the window at one page reads back at that page.
- R9: `out_en_o` and `in_en_o` follow bits 0 and 1 of the last control-register write. They do not depend on the page field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Bus access this cycle |
| req_write_i | input | 1 | 1 selects a write, 0 a read |
| req_addr_i | input | 12 | Byte offset into the direct space |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Registered read data, one cycle after the read |
| rf_addr_o | output | 16 | Internal register-file byte address for the current offset |
| out_en_o | output | 1 | Outbound transfer enable from the control register |
| in_en_o | output | 1 | Inbound transfer enable from the control register |

## Verification
The remap is tried with window offsets under several pages. It is also tried with offsets that have only bit 11 or only bit 10 set, and with the control offset itself. This separates a correct decode of both bits from a decode of only one bit. Data is written at one window offset under two pages and read back under each. A page is selected and used on the very next cycle, which exposes any late page update. Finally, the register-file word that aliases the control offset is written through page 2 and read back after control writes, which shows whether control accesses leak into storage.

// File: rtl/csr_page_pkg.sv
package csr_page_pkg;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned PAGE_W   = 6;
  localparam int unsigned PAGE_LSB = 13;
  localparam int unsigned OFS_W    = 10;
  localparam int unsigned MEM_AW   = 12;
  localparam logic [ADDR_W-1:0] CTRL_OFS = 12'h808;

  typedef enum logic [1:0] {
    ACC_DIRECT = 2'd0,
    ACC_PAGED  = 2'd1,
    ACC_CTRL   = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/csr_page_remap.sv
module csr_page_remap
  import csr_page_pkg::*;
#(
  parameter int unsigned A_W    = ADDR_W,
  parameter int unsigned P_W    = PAGE_W,
  parameter int unsigned O_W    = OFS_W,
  parameter logic [A_W-1:0] C_OFS = CTRL_OFS,
  localparam int unsigned INT_AW = P_W + O_W
) (
  input  logic [A_W-1:0]    addr_i,
  input  logic [P_W-1:0]    page_i,
  output acc_kind_e         kind_o,
  output logic [INT_AW-1:0] int_addr_o
);
  // window select bits sit just above the in-page offset
  logic win_hit;
  assign win_hit = &addr_i[O_W+1:O_W];

  always_comb begin
    int_addr_o = '0;
    kind_o     = ACC_DIRECT;
    if (win_hit) begin
      int_addr_o = {page_i, addr_i[O_W-1:0]};
      kind_o     = ACC_PAGED;
    end else begin
      int_addr_o[A_W-1:0] = addr_i;
      if (addr_i == C_OFS) kind_o = ACC_CTRL;
    end
  end

  always_comb begin
    p_kind_legal_r4: assert (kind_o != ACC_CTRL || !win_hit);
  end
endmodule

// File: rtl/csr_page_ctrl.sv
module csr_page_ctrl
  import csr_page_pkg::*;
#(
  parameter int unsigned D_W   = DATA_W,
  parameter int unsigned P_W   = PAGE_W,
  parameter int unsigned P_LSB = PAGE_LSB
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [D_W-1:0] wdata_i,
  output logic [P_W-1:0] page_o,
  output logic           out_en_o,
  output logic           in_en_o,
  output logic [D_W-1:0] ctrl_word_o
);
  logic [P_W-1:0] page_q;
  logic           out_en_q, in_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q   <= '0;
      out_en_q <= 1'b0;
      in_en_q  <= 1'b0;
    end else if (wr_i) begin
      page_q   <= wdata_i[P_LSB +: P_W];
      out_en_q <= wdata_i[0];
      in_en_q  <= wdata_i[1];
    end
  end

  always_comb begin
    ctrl_word_o                 = '0;
    ctrl_word_o[P_LSB +: P_W]   = page_q;
    ctrl_word_o[0]              = out_en_q;
    ctrl_word_o[1]              = in_en_q;
  end

  assign page_o   = page_q;
  assign out_en_o = out_en_q;
  assign in_en_o  = in_en_q;

  p_page_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> page_o == $past(wdata_i[P_LSB +: P_W]));
  p_page_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(page_o));
  p_en_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (out_en_o == $past(wdata_i[0])) && (in_en_o == $past(wdata_i[1])));
endmodule

// File: rtl/csr_page_regfile.sv
module csr_page_regfile
  import csr_page_pkg::*;
#(
  parameter int unsigned D_W    = DATA_W,
  parameter int unsigned M_AW   = MEM_AW,
  parameter int unsigned INT_AW = PAGE_W + OFS_W,
  localparam int unsigned DEPTH = 1 << M_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [INT_AW-1:0] addr_i,
  input  logic [D_W-1:0]    wdata_i,
  output logic [D_W-1:0]    rdata_o
);
  logic [D_W-1:0]  mem [DEPTH];
  logic [M_AW-1:0] idx;

  assign idx = addr_i[M_AW+1:2];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[idx] <= wdata_i;
  end

  assign rdata_o = mem[idx];

  p_mem_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem[$past(idx)] == $past(wdata_i));
endmodule

// File: rtl/csr_page_decoder.sv
module csr_page_decoder
  import csr_page_pkg::*;
#(
  parameter int unsigned A_W   = ADDR_W,
  parameter int unsigned D_W   = DATA_W,
  parameter int unsigned P_W   = PAGE_W,
  parameter int unsigned P_LSB = PAGE_LSB,
  parameter int unsigned O_W   = OFS_W,
  parameter int unsigned M_AW  = MEM_AW,
  parameter logic [A_W-1:0] C_OFS = CTRL_OFS,
  localparam int unsigned INT_AW = P_W + O_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [A_W-1:0]    req_addr_i,
  input  logic [D_W-1:0]    req_wdata_i,
  output logic [D_W-1:0]    rsp_rdata_o,
  output logic [INT_AW-1:0] rf_addr_o,
  output logic              out_en_o,
  output logic              in_en_o
);
  acc_kind_e      kind;
  logic [P_W-1:0] page;
  logic [D_W-1:0] ctrl_word, rf_rdata, rdata_q;
  logic           ctrl_wr, rf_we, rd_req;

  assign rd_req  = req_valid_i && !req_write_i;
  assign ctrl_wr = req_valid_i && req_write_i && (kind == ACC_CTRL);
  assign rf_we   = req_valid_i && req_write_i && (kind != ACC_CTRL);

  csr_page_remap #(.A_W(A_W), .P_W(P_W), .O_W(O_W), .C_OFS(C_OFS)) u_remap (
    .addr_i     (req_addr_i),
    .page_i     (page),
    .kind_o     (kind),
    .int_addr_o (rf_addr_o)
  );

  csr_page_ctrl #(.D_W(D_W), .P_W(P_W), .P_LSB(P_LSB)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (ctrl_wr),
    .wdata_i     (req_wdata_i),
    .page_o      (page),
    .out_en_o    (out_en_o),
    .in_en_o     (in_en_o),
    .ctrl_word_o (ctrl_word)
  );

  csr_page_regfile #(.D_W(D_W), .M_AW(M_AW), .INT_AW(INT_AW)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we),
    .addr_i  (rf_addr_o),
    .wdata_i (req_wdata_i),
    .rdata_o (rf_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_req) rdata_q <= (kind == ACC_CTRL) ? ctrl_word : rf_rdata;
  end

  assign rsp_rdata_o = rdata_q;

  p_rdata_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> $stable(rsp_rdata_o));
  p_ctrl_rd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && req_addr_i == C_OFS && !ctrl_wr) |=> rsp_rdata_o == $past(ctrl_word));
endmodule

// File: tb/csr_page_decoder_bench.sv
module csr_page_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] rf_addr;
  logic        out_en, in_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_page_decoder u_csr_page_decoder (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(write),
    .req_addr_i(addr), .req_wdata_i(wdata), .rsp_rdata_o(rdata),
    .rf_addr_o(rf_addr), .out_en_o(out_en), .in_en_o(in_en)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        launched = 1'b0;
  bit          done = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk);
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    valid = 1'b1; write = 1'b0; addr = a; wdata = '0;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle();
    valid = 1'b0; write = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_addr(logic [11:0] a, logic [15:0] exp, string tag);
    valid = 1'b0; write = 1'b0; addr = a;
    #1 check(tag, 32'(rf_addr), 32'(exp));
    @(negedge clk);
  endtask

  // monitor: scoreboard pop one cycle after each read
  always @(posedge clk) launched <= valid && !write && rst_n;
  always @(negedge clk) begin
    if (launched && exp_q.size() > 0) begin
      automatic logic [31:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(t, rdata, e);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", rdata, 32'h0);
    check("R1 enables", {30'b0, in_en, out_en}, 32'h0);
    rd(12'h808, 32'h0, "R1 ctrl read");
    idle();
    // R2 / R9 control fields
    wr(12'h808, (32'd3 << 13) | 32'h1);
    rd(12'h808, 32'h0000_6001, "R2 ctrl readback");
    idle();
    check("R9 enables out only", {30'b0, in_en, out_en}, 32'h1);
    wr(12'h808, 32'hFFFF_FFFF);
    rd(12'h808, 32'h0007_E003, "R2 reserved bits zero");
    idle();
    check("R9 both enables", {30'b0, in_en, out_en}, 32'h3);
    wr(12'h808, (32'd5 << 13) | 32'h2);
    idle();
    check("R9 in only with page 5", {30'b0, in_en, out_en}, 32'h2);
    // R3 / R4 address remap
    chk_addr(12'hC24, 16'h1424, "R3 paged addr p5");
    chk_addr(12'hFFC, 16'h17FC, "R3 paged top p5");
    chk_addr(12'h124, 16'h0124, "R4 direct low");
    chk_addr(12'h808, 16'h0808, "R4 ctrl offset direct");
    chk_addr(12'h804, 16'h0804, "R4 bit11 only");
    chk_addr(12'h400, 16'h0400, "R4 bit10 only");
    // R8 distinct pages
    wr(12'h808, 32'd1 << 13);
    wr(12'hC10, 32'hAAAA_0001);
    wr(12'h808, 32'd4 << 13);
    wr(12'hC10, 32'hBBBB_0004);
    wr(12'h808, 32'd1 << 13);
    rd(12'hC10, 32'hAAAA_0001, "R8 page1 readback");
    // R6 page used on the very next access
    wr(12'h808, 32'd4 << 13);
    rd(12'hC10, 32'hBBBB_0004, "R6 next-cycle page4");
    idle();
    // R3/R4 page 0 window aliases direct low space
    wr(12'h010, 32'hCCCC_0000);
    wr(12'h808, 32'h0);
    rd(12'hC10, 32'hCCCC_0000, "R3 page0 alias of direct");
    idle();
    // R5 ctrl writes do not reach internal 0x0808
    wr(12'h808, 32'd2 << 13);
    wr(12'hC08, 32'hDDDD_0808);
    wr(12'h808, (32'd2 << 13) | 32'h3);
    rd(12'hC08, 32'hDDDD_0808, "R5 mem word kept");
    rd(12'h808, 32'h0000_4003, "R5 ctrl read not mem");
    // R7 latency and hold
    wr(12'h020, 32'h1234_5678);
    idle();
    check("R7 hold over write and idle", rdata, 32'h0000_4003);
    rd(12'h020, 32'h1234_5678, "R7 direct readback");
    idle();
    idle();
    check("R7 hold after idles", rdata, 32'h1234_5678);
    check("scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule